// File: doc/BRIEF.md
# Dual Configurable Watermark Sequence Generator

This block produces a single-bit watermark stream for power-signature logic. The stream is meant to gate the clock enable of existing sequential logic. The block holds two independent generators. Each generator is set at run time to one of three modes:

- a Fibonacci linear feedback shift register,
- a Galois linear feedback shift register,
- a plain circular rotate.

Each generator has a programmable active length between 2 and 32 bits. Any length can give a maximal-length sequence, for example the 12-bit sequence of period 4095 taken from 32-bit hardware.

A shared load pulse copies each generator's seed into its state. The enable input advances both generators by one step per clock. When enable is low, the stream is forced low and both generators hold their state. A select input chooses which generator drives the output. A one-cycle strobe from the selected generator marks each return of its state to the loaded seed, which is one full period.

Top module: `wm_seq_gen`

## Requirements
- R1: After the active-low asynchronous reset, every generator state and stored seed is zero, and wmark_o and strobe_o are 0 while en_i is low.
- R2: A clock edge with load_i high sets each generator's state to its seed with bits at and above the active length cleared. In LFSR modes (mode 00 or 01), a seed that is zero after masking is replaced by 1. Rotate mode keeps a zero seed. The load takes priority over en_i.
- R3: While en_i is low, wmark_o is 0 and no generator state changes. Clearing en_i and setting it again continues each sequence from where it stopped.
- R4: Mode 00 (Fibonacci) shifts the active bits up by one. The new bit 0 is the XOR of the state bits at positions (exponent − 1) of the primitive polynomial for the length. For length 12 these are bits 11, 5, 3 and 0 (x^12+x^6+x^4+x+1). The output bit is bit L−1.
- R5: Mode 01 (Galois) outputs bit 0 and shifts the state down by one. When the output bit is 1, the tap mask of R4 is XORed into the shifted state, so for length 12 the mask is 0x829.
- R6: Mode 10 or 11 rotates the L active bits up by one, with bit L−1 entering bit 0. The output bit is bit L−1.
- R7: In either LFSR mode with a nonzero seed, a generator of length L returns to its seed after exactly 2^L − 1 enabled steps, which is 4095 steps for L = 12.
- R8: After an enabled step, strobe_o is high for one cycle if that step brought the selected generator's state back to its stored seed. strobe_o is 0 after a load or after a cycle with en_i low.
- R9: sel_i = 0 routes generator 0 to wmark_o and strobe_o, and sel_i = 1 routes generator 1. Both generators step every enabled cycle whichever one is selected.
- R10: A length field of 0 or 1 acts as length 2. A length field above 32 acts as length 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Step enable; low forces wmark_o to 0 and freezes state |
| load_i | input | 1 | Load all seeds on this edge |
| mode_i | input | 2*NUM_GEN | Per-generator mode: 00 Fibonacci, 01 Galois, 1x rotate |
| len_i | input | LW*NUM_GEN | Per-generator active length field |
| seed_i | input | W*NUM_GEN | Per-generator seed |
| sel_i | input | SW | Generator driving the outputs |
| wmark_o | output | 1 | Watermark bit |
| strobe_o | output | 1 | One-cycle period-complete strobe |

## Verification
A load or a step takes effect at the clock edge where it is applied. The new output bit is visible on wmark_o in the same cycle, because wmark_o is the enable ANDed with a state bit, with no further register. strobe_o is registered in the same edge as the step that returns the state to the seed, so it is due in that same cycle, and it must be low again one cycle later.

The bench drives inputs just after a falling edge and advances its model at the rising edge. It compares both outputs at the next falling edge, so each result is checked exactly one edge after its stimulus. Period checks count the enabled edges from the enable up to the first strobe.

// File: rtl/wm_pkg.sv
package wm_pkg;

  typedef enum logic [1:0] {
    MODE_FIB     = 2'b00,
    MODE_GAL     = 2'b01,
    MODE_ROT     = 2'b10,
    MODE_ROT_ALT = 2'b11
  } gen_mode_e;

  localparam int unsigned MAX_W = 32;

  function automatic logic [MAX_W-1:0] tb(input int unsigned t);
    logic [MAX_W-1:0] m;
    m = '0;
    m[t-1] = 1'b1;
    return m;
  endfunction

  // Primitive polynomial exponents per active length.
  function automatic logic [MAX_W-1:0] tap_mask(input int unsigned len);
    logic [MAX_W-1:0] m;
    case (len)
      2:  m = tb(2)  | tb(1);
      3:  m = tb(3)  | tb(2);
      4:  m = tb(4)  | tb(3);
      5:  m = tb(5)  | tb(3);
      6:  m = tb(6)  | tb(5);
      7:  m = tb(7)  | tb(6);
      8:  m = tb(8)  | tb(6)  | tb(5) | tb(4);
      9:  m = tb(9)  | tb(5);
      10: m = tb(10) | tb(7);
      11: m = tb(11) | tb(9);
      12: m = tb(12) | tb(6)  | tb(4) | tb(1);
      13: m = tb(13) | tb(4)  | tb(3) | tb(1);
      14: m = tb(14) | tb(5)  | tb(3) | tb(1);
      15: m = tb(15) | tb(14);
      16: m = tb(16) | tb(15) | tb(13) | tb(4);
      17: m = tb(17) | tb(14);
      18: m = tb(18) | tb(11);
      19: m = tb(19) | tb(6)  | tb(2) | tb(1);
      20: m = tb(20) | tb(17);
      21: m = tb(21) | tb(19);
      22: m = tb(22) | tb(21);
      23: m = tb(23) | tb(18);
      24: m = tb(24) | tb(23) | tb(22) | tb(17);
      25: m = tb(25) | tb(22);
      26: m = tb(26) | tb(6)  | tb(2) | tb(1);
      27: m = tb(27) | tb(5)  | tb(2) | tb(1);
      28: m = tb(28) | tb(25);
      29: m = tb(29) | tb(27);
      30: m = tb(30) | tb(6)  | tb(4) | tb(1);
      31: m = tb(31) | tb(28);
      default: m = tb(32) | tb(22) | tb(2) | tb(1);
    endcase
    return m;
  endfunction

  function automatic logic [MAX_W-1:0] len_mask(input int unsigned len);
    logic [MAX_W-1:0] m;
    for (int unsigned i = 0; i < MAX_W; i++) m[i] = (i < len);
    return m;
  endfunction

  function automatic int unsigned eff_len(input int unsigned raw, input int unsigned w);
    if (raw < 2) return 2;
    if (raw > w) return w;
    return raw;
  endfunction

endpackage

// File: rtl/wm_gen.sv
module wm_gen #(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [1:0]    mode_i,
  input  logic [LW-1:0] len_i,
  input  logic [W-1:0]  seed_i,
  output logic          bit_o,
  output logic [W-1:0]  state_o,
  output logic          wrap_o
);
  import wm_pkg::*;

  localparam int IW = $clog2(W);

  gen_mode_e     mode;
  int unsigned   act_len;
  logic [IW-1:0] top_idx;
  logic [W-1:0]  lmask, tmask, cur, seed_fix, nxt;
  logic [W-1:0]  state_q, seed_q;
  logic          wrap_q, is_lfsr;

  assign mode = gen_mode_e'(mode_i);

  always_comb begin
    act_len  = eff_len(32'(len_i), W);
    top_idx  = IW'(act_len - 1);
    lmask    = W'(len_mask(act_len));
    tmask    = W'(tap_mask(act_len));
    cur      = state_q & lmask;
    is_lfsr  = (mode == MODE_FIB) || (mode == MODE_GAL);
    seed_fix = seed_i & lmask;
    if (is_lfsr && seed_fix == '0) seed_fix = W'(1);
    case (mode)
      MODE_FIB: nxt = ((cur << 1) | W'(^(cur & tmask))) & lmask;
      MODE_GAL: nxt = (cur >> 1) ^ (cur[0] ? tmask : '0);
      default:  nxt = ((cur << 1) | W'(cur[top_idx])) & lmask;
    endcase
    bit_o = (mode == MODE_GAL) ? cur[0] : cur[top_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      seed_q  <= '0;
      wrap_q  <= 1'b0;
    end else if (load_i) begin
      state_q <= seed_fix;
      seed_q  <= seed_fix;
      wrap_q  <= 1'b0;
    end else if (en_i) begin
      state_q <= nxt;
      wrap_q  <= (nxt == seed_q);
    end else begin
      wrap_q  <= 1'b0;
    end
  end

  assign state_o = state_q;
  assign wrap_o  = wrap_q;

endmodule

// File: rtl/wm_out_mux.sv
module wm_out_mux #(
  parameter int N  = 2,
  parameter int SW = 1
) (
  input  logic [N-1:0]  bit_i,
  input  logic [N-1:0]  wrap_i,
  input  logic [SW-1:0] sel_i,
  input  logic          en_i,
  output logic          wmark_o,
  output logic          strobe_o
);
  always_comb begin
    wmark_o  = 1'b0;
    strobe_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (32'(sel_i) == i) begin
        wmark_o  = en_i & bit_i[i];
        strobe_o = wrap_i[i];
      end
    end
  end
endmodule

// File: rtl/wm_seq_gen.sv
module wm_seq_gen #(
  parameter int NUM_GEN = 2,
  parameter int W       = 32,
  localparam int LW     = $clog2(W) + 1,
  localparam int SW     = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  load_i,
  input  logic [2*NUM_GEN-1:0]  mode_i,
  input  logic [LW*NUM_GEN-1:0] len_i,
  input  logic [W*NUM_GEN-1:0]  seed_i,
  input  logic [SW-1:0]         sel_i,
  output logic                  wmark_o,
  output logic                  strobe_o
);

  logic [NUM_GEN-1:0]   gen_bit, gen_wrap;
  logic [W*NUM_GEN-1:0] state_flat;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    wm_gen #(.W(W), .LW(LW)) u_gen (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .load_i  (load_i),
      .mode_i  (mode_i[2*g +: 2]),
      .len_i   (len_i[LW*g +: LW]),
      .seed_i  (seed_i[W*g +: W]),
      .bit_o   (gen_bit[g]),
      .state_o (state_flat[W*g +: W]),
      .wrap_o  (gen_wrap[g])
    );
  end

  wm_out_mux #(.N(NUM_GEN), .SW(SW)) u_mux (
    .bit_i    (gen_bit),
    .wrap_i   (gen_wrap),
    .sel_i    (sel_i),
    .en_i     (en_i),
    .wmark_o  (wmark_o),
    .strobe_o (strobe_o)
  );

endmodule

// File: rtl/wm_seq_gen_chk.sv
module wm_seq_gen_chk #(
  parameter int NUM_GEN = 2,
  parameter int W       = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 load_i,
  input logic [2*NUM_GEN-1:0] mode_i,
  input logic                 wmark_o,
  input logic                 strobe_o,
  input logic [W*NUM_GEN-1:0] state_flat_i
);

  assert_dis_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !wmark_o);

  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> (state_flat_i == $past(state_flat_i)));

  assert_strobe_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || load_i) |=> !strobe_o);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    assert_lfsr_seed_nz_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && (mode_i[2*g +: 2] inside {2'b00, 2'b01})) |=> (state_flat_i[W*g +: W] != '0));
  end

endmodule

bind wm_seq_gen wm_seq_gen_chk #(.NUM_GEN(NUM_GEN), .W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .load_i       (load_i),
  .mode_i       (mode_i),
  .wmark_o      (wmark_o),
  .strobe_o     (strobe_o),
  .state_flat_i (state_flat)
);

// File: tb/wm_seq_gen_tb.sv
module wm_seq_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 2;
  localparam int W  = 32;
  localparam int LW = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, load_i = 1'b0;
  logic [2*NG-1:0]  mode_i = '0;
  logic [LW*NG-1:0] len_i = '0;
  logic [W*NG-1:0]  seed_i = '0;
  logic [0:0]       sel_i = '0;
  logic wmark_o, strobe_o;

  int nchk = 0, nerr = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [31:0] ms [NG];
  logic [31:0] mseed [NG];
  bit mstb [NG];
  bit trk [NG];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wm_seq_gen #(.NUM_GEN(NG), .W(W)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned m_len(int g);
    int unsigned r = 32'(len_i[LW*g +: LW]);
    return (r < 2) ? 2 : (r > 32) ? 32 : r;
  endfunction

  function automatic logic [31:0] m_mask(int unsigned l);
    return (l >= 32) ? 32'hFFFF_FFFF : ((32'd1 << l) - 1);
  endfunction

  function automatic logic [31:0] m_next(logic [1:0] md, int unsigned l, logic [31:0] s);
    case (md)
      2'b00:   return ((s << 1) | 32'(^(s & 32'h829))) & m_mask(l);
      2'b01:   return (s >> 1) ^ (s[0] ? 32'h829 : 32'h0);
      default: return ((s << 1) | 32'(s[l-1])) & m_mask(l);
    endcase
  endfunction

  function automatic logic m_bit(logic [1:0] md, int unsigned l, logic [31:0] s);
    return (md == 2'b01) ? s[0] : s[l-1];
  endfunction

  task automatic cyc();
    @(posedge clk_i);
    for (int g = 0; g < NG; g++) begin
      logic [1:0] md = mode_i[2*g +: 2];
      int unsigned l = m_len(g);
      if (load_i) begin
        logic [31:0] f = seed_i[W*g +: W] & m_mask(l);
        if (!md[1] && f == 0) f = 32'd1;
        ms[g] = f; mseed[g] = f; mstb[g] = 0;
      end else if (en_i) begin
        logic [31:0] n = m_next(md, l, ms[g]);
        mstb[g] = (n == mseed[g]);
        ms[g] = n;
      end else mstb[g] = 0;
    end
    @(negedge clk_i);
    if (trk[sel_i]) begin
      int s = int'(sel_i);
      check(cur_req, 32'(wmark_o), 32'(en_i & m_bit(mode_i[2*s +: 2], m_len(s), ms[s])));
      check(cur_req, 32'(strobe_o), 32'(mstb[s]));
    end
  endtask

  task automatic cfg(int g, logic [1:0] md, int raw, logic [31:0] sd);
    mode_i[2*g +: 2] = md;
    len_i[LW*g +: LW] = LW'(raw);
    seed_i[W*g +: W] = sd;
  endtask

  task automatic do_load();
    load_i = 1; en_i = 0; cyc(); load_i = 0;
  endtask

  task automatic run(int n, bit rnd_en, bit rnd_sel);
    for (int i = 0; i < n; i++) begin
      en_i = rnd_en ? ($urandom % 3 != 0) : 1'b1;
      if (rnd_sel) sel_i = 1'($urandom);
      cyc();
    end
    en_i = 0;
  endtask

  task automatic period(logic [1:0] md, int raw, logic [31:0] sd, int exp, string req);
    int cnt = 0;
    trk[0] = 0; trk[1] = 0; sel_i = 0;
    cfg(0, md, raw, sd);
    do_load();
    en_i = 1;
    do begin cyc(); cnt++; end while (!strobe_o && cnt < exp + 10);
    check(req, cnt, exp);
    cyc();
    check("R8", 32'(strobe_o), 0);
    en_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int g = 0; g < NG; g++) begin ms[g] = 0; mseed[g] = 0; mstb[g] = 0; trk[g] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1: reset state
    cyc(); cyc();
    check("R1", 32'(wmark_o), 0);
    check("R1", 32'(strobe_o), 0);
    trk[0] = 1; cur_req = "R1"; cyc();

    // R4: Fibonacci 12 bit stream
    cur_req = "R4"; cfg(0, 2'b00, 12, ($urandom & 32'hFFF) | 32'h1);
    do_load(); run(300, 0, 0);
    // R5: Galois 12 bit stream, high seed bits masked
    cur_req = "R5"; cfg(0, 2'b01, 12, $urandom | 32'hF000_0001);
    do_load(); run(300, 0, 0);
    // R2: zero seed after masking becomes 1 in LFSR mode
    cur_req = "R2"; cfg(0, 2'b00, 12, 32'hFFFF_F000);
    load_i = 1; en_i = 1; cyc(); load_i = 0;
    run(60, 0, 0);
    cfg(0, 2'b01, 12, 32'h0); do_load(); run(40, 0, 0);
    cfg(0, 2'b10, 9, 32'h0); do_load(); run(20, 0, 0);
    // R3: random enable gaps freeze state
    cur_req = "R3"; cfg(0, 2'b00, 12, $urandom);
    do_load(); run(400, 1, 0);
    // R6: rotate with random lengths and seeds
    cur_req = "R6";
    for (int t = 0; t < 6; t++) begin
      int l = 2 + ($urandom % 31);
      cfg(0, (t % 2) ? 2'b11 : 2'b10, l, $urandom);
      do_load(); run(2 * l + 3, 1, 0);
    end
    // R9: both generators, random select
    cur_req = "R9"; trk[1] = 1;
    cfg(0, 2'b01, 12, $urandom); cfg(1, 2'b10, 7, $urandom | 32'h1);
    do_load(); run(300, 1, 1);
    cfg(0, 2'b10, 5, 32'h3); cfg(1, 2'b00, 12, $urandom);
    do_load(); run(200, 0, 1);
    // R7: maximal periods
    period(2'b00, 12, 32'h5A5, 4095, "R7");
    period(2'b01, 12, 32'h001, 4095, "R7");
    for (int l = 2; l < 12; l++) begin
      period(2'b00, l, 32'h1, (1 << l) - 1, "R7");
      period(2'b01, l, 32'hFFFF_FFFF, (1 << l) - 1, "R7");
    end
    // R10: length clamp
    period(2'b00, 0, 32'h1, 3, "R10");
    period(2'b01, 1, 32'h2, 3, "R10");
    period(2'b10, 40, 32'h1, 32, "R10");
    period(2'b11, 63, 32'h8000_0001, 32, "R10");
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule